// File: doc/BRIEF.md
# Fixed latency load return buffer

This block sits between a memory whose response time varies and a pipeline whose schedule is fixed when the code is built. Software programs a latency value, and every load issued afterwards must hand its data to the pipeline exactly that many cycles after its issue cycle. When memory is fast, the returned data is parked in a slot until its due cycle. When memory is slow, the block raises a stall as soon as a due cycle passes with no data, and it releases the data on the first cycle that the data is present.

Each outstanding load occupies one of eight slots. The slot number is the tag that travels with the request to memory and comes back with the response, so responses may return in any order. Due times are kept against an internal time base that stops while the pipeline is stalled. Loads already in flight therefore keep their scheduled spacing relative to one another.

Top module: `load_return_buffer`

## Requirements
- R1: After reset, wb_valid and stall are low, iss_ready is high with iss_tag equal to 0, and the latency register holds 4.
- R2: A load whose response is presented at least one cycle before its due cycle is written back exactly L cycles after its issue cycle (L = latency in force at issue), with stall low throughout.
- R3: If the response for a load with latency L is presented in cycle issue+d with d >= L, stall is high in cycles issue+L through issue+d and the writeback occurs in cycle issue+d+1.
- R4: A latency write takes effect for loads issued in later cycles; a load issued in the same cycle as the write uses the earlier value. A written value of 0 is stored as 1.
- R5: While stall is high the time base does not advance, so a load due k time steps after a stalled load is written back exactly k cycles after the stalled load's writeback.
- R6: A new load is given the lowest-numbered free slot (0 to 7) as its tag, shown on iss_tag, and that tag is not offered again until the load has been written back.
- R7: iss_ready is low whenever all eight slots are busy and in every cycle in which stall is high.
- R8: Responses are matched to loads by rsp_tag, in any order; each writeback carries the destination given at issue and the data returned under that tag.
- R9: At most one writeback happens per cycle. When two loads with data are due in the same cycle, the lower tag is written back first while stall is held high, and the other follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lat_we | input | 1 | Latency register write strobe |
| lat_val | input | LAT_W (5) | New latency in cycles |
| iss_valid | input | 1 | Pipeline issues a load this cycle |
| iss_dest | input | DEST_W (5) | Destination register of the issued load |
| iss_ready | output | 1 | A load can be accepted this cycle |
| iss_tag | output | TAG_W (3) | Tag given to the load issued this cycle |
| rsp_valid | input | 1 | Memory returns data this cycle |
| rsp_tag | input | TAG_W (3) | Tag of the returning load |
| rsp_data | input | DATA_W (32) | Returned load data |
| wb_valid | output | 1 | Load result delivered to the pipeline |
| wb_dest | output | DEST_W (5) | Destination of the delivered result |
| wb_data | output | DATA_W (32) | Delivered load data |
| stall | output | 1 | Pipeline must hold this cycle |

## Verification
On every cycle the assertions confirm that the time base holds still exactly when stall is high and otherwise steps by one. They also confirm that an accepted tag is never offered again on the next cycle and that the latency register always holds the clamped value of the latest write. Exact delivery cycles, stall lengths for late data, ordering of same-cycle deliveries, tag matching for responses returned out of order, and the reset latency are checked only by the bench scenarios. Those scenarios compare writeback timing and content against cycle counts worked out from the requirements.

// File: rtl/lrb_pkg.sv
// Shared types for the fixed latency load return buffer.
// Assumes: nothing beyond standard SystemVerilog.
package lrb_pkg;

    // Life cycle of one buffer slot.
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,   // free for a new load
        SLOT_WAIT = 2'd1,   // load issued, memory data not yet back
        SLOT_HELD = 2'd2    // data back, waiting for its due cycle
    } slot_state_e;

endpackage

// File: rtl/lrb_prio_pick.sv
// Lowest-index priority picker.
// Returns whether any request bit is set and the index of the lowest one.
// Assumes: IDX_W is wide enough to hold N-1.
module lrb_prio_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/lrb_latency_reg.sv
// Software-written load latency register.
// A written value of zero is stored as one so every load takes at least
// one cycle. Assumes LAT_RESET is non-zero.
module lrb_latency_reg #(
    parameter int LAT_W     = 5,
    parameter int LAT_RESET = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [LAT_W-1:0] val_i,
    output logic [LAT_W-1:0] lat_o
);

    // Hold the latency, clamping a zero write up to one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_o <= LAT_W'(LAT_RESET);
        end else if (we_i) begin
            lat_o <= (val_i == '0) ? LAT_W'(1) : val_i;
        end
    end

endmodule

// File: rtl/lrb_timebase.sv
// Schedule time base. Counts cycles in which the pipeline advances and
// holds while it is stalled. Assumes CNT_W is at least one bit wider than
// the latency field so a due time never aliases a pending one.
module lrb_timebase #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance_i,
    output logic [CNT_W-1:0] now_o
);

    // Step the time base only on cycles the pipeline moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_o <= '0;
        end else if (advance_i) begin
            now_o <= now_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lrb_slot.sv
// One outstanding-load slot: due time, destination and returned data.
// Captures a response whose tag equals SLOT_ID while waiting, and is freed
// when the top selects it for writeback. Assumes alloc_i is only raised
// while the slot is idle and release_i only while it holds data.
module lrb_slot #(
    parameter int DATA_W  = 32,
    parameter int DEST_W  = 5,
    parameter int CNT_W   = 6,
    parameter int TAG_W   = 3,
    parameter int SLOT_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [CNT_W-1:0]  due_i,
    input  logic [DEST_W-1:0] dest_i,
    input  logic              rsp_valid_i,
    input  logic [TAG_W-1:0]  rsp_tag_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    input  logic              release_i,
    input  logic [CNT_W-1:0]  now_i,
    output logic              busy_o,
    output logic              held_o,
    output logic              due_now_o,
    output logic [DEST_W-1:0] dest_o,
    output logic [DATA_W-1:0] data_o
);

    localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(SLOT_ID);

    lrb_pkg::slot_state_e state_q;
    logic [CNT_W-1:0]     due_q;
    logic                 rsp_hit;

    assign rsp_hit = rsp_valid_i && (rsp_tag_i == MY_TAG);

    // Move the slot through idle, waiting and holding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= lrb_pkg::SLOT_IDLE;
        end else if (alloc_i) begin
            state_q <= lrb_pkg::SLOT_WAIT;
        end else if (release_i) begin
            state_q <= lrb_pkg::SLOT_IDLE;
        end else if (state_q == lrb_pkg::SLOT_WAIT && rsp_hit) begin
            state_q <= lrb_pkg::SLOT_HELD;
        end
    end

    // Record due time and destination when the load is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            due_q  <= '0;
            dest_o <= '0;
        end else if (alloc_i) begin
            due_q  <= due_i;
            dest_o <= dest_i;
        end
    end

    // Capture memory data for this tag while the slot waits for it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
        end else if (state_q == lrb_pkg::SLOT_WAIT && rsp_hit) begin
            data_o <= rsp_data_i;
        end
    end

    assign busy_o    = (state_q != lrb_pkg::SLOT_IDLE);
    assign held_o    = (state_q == lrb_pkg::SLOT_HELD);
    assign due_now_o = busy_o && (due_q == now_i);

endmodule

// File: rtl/load_return_buffer.sv
// Fixed latency load return buffer.
// Gives each issued load a slot tag and a due time (time base plus the
// programmed latency), parks early data until the due time, and stalls the
// pipeline while a due load has no data or more than one load is due.
// Assumes: one issue and one response per cycle; the time base freezes
// during stall so due times stay aligned with the static schedule.
module load_return_buffer #(
    parameter int NUM_SLOTS = 8,
    parameter int DATA_W    = 32,
    parameter int DEST_W    = 5,
    parameter int LAT_W     = 5,
    parameter int LAT_RESET = 4,
    localparam int TAG_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int CNT_W    = LAT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_we,
    input  logic [LAT_W-1:0]  lat_val,
    input  logic              iss_valid,
    input  logic [DEST_W-1:0] iss_dest,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              wb_valid,
    output logic [DEST_W-1:0] wb_dest,
    output logic [DATA_W-1:0] wb_data,
    output logic              stall
);

    logic [LAT_W-1:0]     lat_q;
    logic [CNT_W-1:0]     now;
    logic [CNT_W-1:0]     alloc_due;
    logic [NUM_SLOTS-1:0] busy;
    logic [NUM_SLOTS-1:0] held;
    logic [NUM_SLOTS-1:0] due_now;
    logic [NUM_SLOTS-1:0] ready_due;
    logic [NUM_SLOTS-1:0] late_due;
    logic [DEST_W-1:0]    dest_arr [NUM_SLOTS];
    logic [DATA_W-1:0]    data_arr [NUM_SLOTS];
    logic                 free_found;
    logic [TAG_W-1:0]     free_idx;
    logic                 wb_found;
    logic [TAG_W-1:0]     wb_idx;
    logic                 accept;
    logic                 multi_due;

    lrb_latency_reg #(
        .LAT_W     (LAT_W),
        .LAT_RESET (LAT_RESET)
    ) i_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (lat_we),
        .val_i (lat_val),
        .lat_o (lat_q)
    );

    lrb_timebase #(
        .CNT_W (CNT_W)
    ) i_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (!stall),
        .now_o     (now)
    );

    // Free-slot search: lowest idle slot becomes the next tag.
    lrb_prio_pick #(
        .N     (NUM_SLOTS),
        .IDX_W (TAG_W)
    ) i_free_pick (
        .req_i   (~busy),
        .found_o (free_found),
        .idx_o   (free_idx)
    );

    // Writeback search: lowest due slot that already holds data.
    lrb_prio_pick #(
        .N     (NUM_SLOTS),
        .IDX_W (TAG_W)
    ) i_wb_pick (
        .req_i   (ready_due),
        .found_o (wb_found),
        .idx_o   (wb_idx)
    );

    assign alloc_due = now + CNT_W'(lat_q);
    assign accept    = iss_valid && iss_ready;

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            lrb_slot #(
                .DATA_W  (DATA_W),
                .DEST_W  (DEST_W),
                .CNT_W   (CNT_W),
                .TAG_W   (TAG_W),
                .SLOT_ID (s)
            ) i_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .alloc_i     (accept && (free_idx == TAG_W'(s))),
                .due_i       (alloc_due),
                .dest_i      (iss_dest),
                .rsp_valid_i (rsp_valid),
                .rsp_tag_i   (rsp_tag),
                .rsp_data_i  (rsp_data),
                .release_i   (wb_found && (wb_idx == TAG_W'(s))),
                .now_i       (now),
                .busy_o      (busy[s]),
                .held_o      (held[s]),
                .due_now_o   (due_now[s]),
                .dest_o      (dest_arr[s]),
                .data_o      (data_arr[s])
            );
        end
    endgenerate

    // Classify due slots and derive the stall condition.
    always_comb begin
        ready_due = due_now & held;
        late_due  = due_now & ~held;
        multi_due = |(due_now & (due_now - NUM_SLOTS'(1)));
        stall     = (|late_due) || multi_due;
    end

    // Drive the issue and writeback ports.
    always_comb begin
        iss_ready = free_found && !stall;
        iss_tag   = free_idx;
        wb_valid  = wb_found;
        wb_dest   = dest_arr[wb_idx];
        wb_data   = data_arr[wb_idx];
    end

endmodule

// File: rtl/load_return_buffer_chk.sv
// Assertion checker for load_return_buffer, attached with bind below.
// Watches the time base, the tag offered at issue and the latency register.
module load_return_buffer_chk #(
    parameter int LAT_W = 5,
    parameter int TAG_W = 3,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lat_we,
    input logic [LAT_W-1:0] lat_val,
    input logic [LAT_W-1:0] lat_q,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic [TAG_W-1:0] iss_tag,
    input logic             stall,
    input logic [CNT_W-1:0] now
);

    // R5
    time_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (now == $past(now)));

    // R5
    time_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (now == $past(now) + CNT_W'(1)));

    // R6
    tag_not_reoffered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> !(iss_ready && (iss_tag == $past(iss_tag))));

    // R4
    lat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat_we |=> (lat_q == (($past(lat_val) == '0) ? LAT_W'(1) : $past(lat_val))));

    // R4
    lat_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q != '0);

endmodule

bind load_return_buffer load_return_buffer_chk #(
    .LAT_W (LAT_W),
    .TAG_W (TAG_W),
    .CNT_W (CNT_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lat_we    (lat_we),
    .lat_val   (lat_val),
    .lat_q     (lat_q),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_tag   (iss_tag),
    .stall     (stall),
    .now       (now)
);

// File: tb/test_load_return_buffer.sv
// Bench for load_return_buffer: a table of single-load timing vectors
// followed by directed tests for reset, fill, latency change, same-cycle
// due collision and stall freezing.
module test_load_return_buffer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lat_we;
    logic [4:0]  lat_val;
    logic        iss_valid;
    logic [4:0]  iss_dest;
    logic        iss_ready;
    logic [2:0]  iss_tag;
    logic        rsp_valid;
    logic [2:0]  rsp_tag;
    logic [31:0] rsp_data;
    logic        wb_valid;
    logic [4:0]  wb_dest;
    logic [31:0] wb_data;
    logic        stall;

    int checks   = 0;
    int failures = 0;

    // 250 MHz clock
    always #2 clk = ~clk;

    load_return_buffer i_load_return_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat_we    (lat_we),
        .lat_val   (lat_val),
        .iss_valid (iss_valid),
        .iss_dest  (iss_dest),
        .iss_ready (iss_ready),
        .iss_tag   (iss_tag),
        .rsp_valid (rsp_valid),
        .rsp_tag   (rsp_tag),
        .rsp_data  (rsp_data),
        .wb_valid  (wb_valid),
        .wb_dest   (wb_dest),
        .wb_data   (wb_data),
        .stall     (stall)
    );

    // Per vector: latency, response cycle after issue, expected writeback
    // cycle after issue, expected stall cycles.
    localparam int NVEC = 11;
    localparam logic [7:0] VEC [NVEC][4] = '{
        '{8'd4,  8'd1,  8'd4,  8'd0},
        '{8'd4,  8'd3,  8'd4,  8'd0},
        '{8'd4,  8'd4,  8'd5,  8'd1},
        '{8'd4,  8'd6,  8'd7,  8'd3},
        '{8'd1,  8'd1,  8'd2,  8'd1},
        '{8'd2,  8'd1,  8'd2,  8'd0},
        '{8'd7,  8'd2,  8'd7,  8'd0},
        '{8'd10, 8'd9,  8'd10, 8'd0},
        '{8'd10, 8'd12, 8'd13, 8'd3},
        '{8'd0,  8'd1,  8'd2,  8'd1},
        '{8'd31, 8'd5,  8'd31, 8'd0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: run did not finish act=%0d exp=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
        $finish;
    end

    initial begin
        logic [2:0] ta;
        logic [2:0] tb;
        int first;
        int stalls;
        int n;
        int wa;
        int wbk;
        logic [4:0]  got_dest;
        logic [31:0] got_data;

        rst_n = 1'b0; lat_we = 1'b0; lat_val = '0; iss_valid = 1'b0;
        iss_dest = '0; rsp_valid = 1'b0; rsp_tag = '0; rsp_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(!wb_valid && !stall, "R1", "wb/stall after reset", {wb_valid, stall}, 0);
        chk(iss_ready && iss_tag == 3'd0, "R1", "ready/tag after reset", iss_tag, 0);

        // R1: reset latency of 4
        iss_valid = 1'b1; iss_dest = 5'd7;
        @(negedge clk);
        iss_valid = 1'b0;
        first = -1;
        for (int k = 1; k <= 10; k++) begin
            rsp_valid = (k == 1); rsp_tag = 3'd0; rsp_data = 32'h1234;
            if (wb_valid && first < 0) first = k;
            @(negedge clk);
        end
        rsp_valid = 1'b0;
        chk(first == 4, "R1", "reset latency writeback cycle", first, 4);

        // Table of single-load vectors (R2, R3, R4 clamp)
        for (int v = 0; v < NVEC; v++) begin
            lat_we = 1'b1; lat_val = VEC[v][0][4:0];
            @(negedge clk);
            lat_we = 1'b0;
            iss_valid = 1'b1; iss_dest = 5'(v);
            ta = iss_tag;
            @(negedge clk);
            iss_valid = 1'b0;
            first = -1; stalls = 0; got_dest = '0; got_data = '0;
            for (int k = 1; k <= 40; k++) begin
                rsp_valid = (k == int'(VEC[v][1])); rsp_tag = ta;
                rsp_data = 32'h0000_A000 + 32'(v);
                if (stall) stalls++;
                if (wb_valid && first < 0) begin
                    first = k; got_dest = wb_dest; got_data = wb_data;
                end
                @(negedge clk);
            end
            rsp_valid = 1'b0;
            chk(first == int'(VEC[v][2]), (VEC[v][3] == 0) ? "R2" : "R3",
                "writeback cycle", first, VEC[v][2]);
            chk(stalls == int'(VEC[v][3]), (VEC[v][3] == 0) ? "R2" : "R3",
                "stall cycles", stalls, VEC[v][3]);
            chk(got_data == 32'h0000_A000 + 32'(v) && got_dest == 5'(v), "R8",
                "writeback data", got_data, 32'h0000_A000 + v);
        end

        // R6, R7, R8: fill all slots, respond in reverse order
        lat_we = 1'b1; lat_val = 5'd20;
        @(negedge clk);
        lat_we = 1'b0;
        for (int i = 0; i < 8; i++) begin
            iss_valid = 1'b1; iss_dest = 5'(16 + i);
            chk(iss_ready && iss_tag == 3'(i), "R6", "tag on fill", iss_tag, i);
            @(negedge clk);
        end
        iss_valid = 1'b0;
        n = 0;
        for (int k = 8; k <= 40; k++) begin
            if (k == 8) chk(!iss_ready, "R7", "ready when full", iss_ready, 0);
            rsp_valid = (k <= 15); rsp_tag = 3'(15 - k);
            rsp_data = 32'h0000_B000 + 32'(15 - k);
            if (wb_valid) begin
                chk(k == 20 + n && wb_dest == 5'(16 + n) && wb_data == 32'h0000_B000 + 32'(n),
                    "R8", "out-of-order match dest", wb_dest, 16 + n);
                n++;
            end
            @(negedge clk);
        end
        rsp_valid = 1'b0;
        chk(n == 8, "R8", "writebacks after fill", n, 8);

        // R4: write in the issue cycle does not apply to that load
        lat_we = 1'b1; lat_val = 5'd3;
        @(negedge clk);
        lat_val = 5'd8; iss_valid = 1'b1; iss_dest = 5'd1; ta = iss_tag;
        @(negedge clk);
        lat_we = 1'b0; iss_dest = 5'd2; tb = iss_tag;
        rsp_valid = 1'b1; rsp_tag = ta; rsp_data = 32'hC1;
        @(negedge clk);
        iss_valid = 1'b0; rsp_tag = tb; rsp_data = 32'hC2;
        @(negedge clk);
        rsp_valid = 1'b0;
        wa = -1; wbk = -1;
        for (int k = 3; k <= 15; k++) begin
            if (wb_valid && wb_dest == 5'd1) wa = k;
            if (wb_valid && wb_dest == 5'd2) wbk = k;
            @(negedge clk);
        end
        chk(wa == 3, "R4", "load issued with write uses old latency", wa, 3);
        chk(wbk == 9, "R4", "next load uses new latency", wbk, 9);

        // R9, R7: two loads due together
        lat_we = 1'b1; lat_val = 5'd6;
        @(negedge clk);
        lat_val = 5'd3; iss_valid = 1'b1; iss_dest = 5'd3; ta = iss_tag;
        @(negedge clk);
        lat_we = 1'b0; iss_valid = 1'b0;
        rsp_valid = 1'b1; rsp_tag = ta; rsp_data = 32'hD3;
        @(negedge clk);
        rsp_valid = 1'b0;
        @(negedge clk);
        iss_valid = 1'b1; iss_dest = 5'd4; tb = iss_tag;
        @(negedge clk);
        iss_valid = 1'b0;
        rsp_valid = 1'b1; rsp_tag = tb; rsp_data = 32'hD4;
        @(negedge clk);
        rsp_valid = 1'b0;
        @(negedge clk);
        chk(wb_valid && wb_dest == 5'd3 && ta < tb, "R9", "lower tag first", wb_dest, 3);
        chk(stall, "R9", "stall while second due", stall, 1);
        chk(!iss_ready, "R7", "ready during stall", iss_ready, 0);
        @(negedge clk);
        chk(wb_valid && wb_dest == 5'd4 && wb_data == 32'hD4, "R9", "second load next cycle", wb_dest, 4);
        chk(!stall, "R9", "stall released", stall, 0);
        @(negedge clk);
        chk(!wb_valid, "R9", "no extra writeback", wb_valid, 0);

        // R5, R3: late load freezes time, later load keeps spacing
        lat_we = 1'b1; lat_val = 5'd2;
        @(negedge clk);
        lat_we = 1'b0; iss_valid = 1'b1; iss_dest = 5'd5; ta = iss_tag;
        @(negedge clk);
        iss_dest = 5'd6; tb = iss_tag;
        @(negedge clk);
        iss_valid = 1'b0;
        wa = -1; wbk = -1; stalls = 0;
        for (int k = 2; k <= 12; k++) begin
            rsp_valid = (k == 2) || (k == 4);
            rsp_tag   = (k == 2) ? tb : ta;
            rsp_data  = (k == 2) ? 32'hE6 : 32'hE5;
            if (k == 3) chk(!iss_ready, "R7", "ready during late stall", iss_ready, 0);
            if (stall) stalls++;
            if (wb_valid && wb_dest == 5'd5) wa = k;
            if (wb_valid && wb_dest == 5'd6) wbk = k;
            @(negedge clk);
        end
        rsp_valid = 1'b0;
        chk(wa == 5, "R3", "late load writeback cycle", wa, 5);
        chk(stalls == 3, "R3", "late load stall cycles", stalls, 3);
        chk(wbk == wa + 1, "R5", "spacing kept after stall", wbk, wa + 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule